// File: doc/BRIEF.md
# Tiled Fixed-Point Matrix Multiplier with Transposed Right Operand

This block computes C = A × Bᵀ on signed 16-bit fixed-point data. A is an M×K matrix and the right operand is supplied already transposed, as an N×K matrix. Both are stored row-major in external memory, so a row of either operand is a run of consecutive addresses. The result C is M×N and is also row-major. The block works one output tile at a time. For each slice of K it fills two on-chip tile buffers through two read ports. A square array of multiply-accumulate cells then adds the slice into a set of 32-bit accumulators. After the last slice of K, the tile is narrowed to 16 bits and written out through a write port.

The caller gives the three matrix dimensions and three tile sizes on the cycle that `start` is raised. The tile sizes may differ from call to call, up to a compile-time maximum. The last tiles along any dimension may be partial. Operand elements outside the matrix are not read and enter the buffers as zero. Result elements outside the matrix are never written. An optional per-row bias can be fetched through a third read port. Running a batch of fully connected inputs needs nothing extra: the batch is simply a larger N.

Top module: `xpose_matmul`

## Requirements
- R1: After reset, `busy`, `done`, `a_rd_en`, `b_rd_en`, `bias_rd_en` and `c_wr_en` are all low.
- R2: Addressing is row-major: A element (m,k) is at address m·K+k, transposed operand element (n,k) is at n·K+k, bias of row m is at address m, and result (m,n) is written at m·N+n. The result is C(m,n) = narrow((Σk A(m,k)·B(n,k) + bias(m)·2^F) >>> F). The sum is taken modulo 2^32 in a signed 32-bit accumulator, and F is the fractional shift (default 8).
- R3: Narrowing saturates to the signed 16-bit range: values above 32767 give 32767 and values below −32768 give −32768.
- R4: With the bias option enabled, the bias of each row is added exactly once per output element, after the last K slice, however many K slices the tile needs.
- R5: Within one buffer row, operand reads are issued on consecutive cycles at consecutive addresses, with k running fastest.
- R6: No read is issued for an operand element outside the matrix. Such elements act as zero, so partial edge tiles give exact results.
- R7: Every element of C inside the M×N bounds is written exactly once per call. No write goes to a position outside the bounds.
- R8: Tile sizes are taken per call from the tile inputs. A requested size of 0 is treated as 1, and a size above the maximum tile edge (default 4) is treated as the maximum. Results do not depend on the tile sizes.
- R9: `busy` is high from the cycle after an accepted `start` until the last write. `done` is then high for exactly one cycle, with `busy` low, and both are low in the following cycle.
- R10: `start` is ignored while `busy` is high. The dimensions and tile sizes of the running call stay in force.
- R11: A call in which any of M, N or K is zero raises `done` without issuing any read or write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a call; sampled only when idle |
| dim_m | input | DIM_W | Rows of A and C |
| dim_n | input | DIM_W | Rows of the transposed operand, columns of C |
| dim_k | input | DIM_W | Shared inner dimension |
| tile_m | input | IW+1 | Requested tile height |
| tile_n | input | IW+1 | Requested tile width |
| tile_k | input | IW+1 | Requested K slice depth |
| busy | output | 1 | Call in progress |
| done | output | 1 | One-cycle end-of-call pulse |
| a_rd_en | output | 1 | A read request |
| a_rd_addr | output | ADDR_W | A read address |
| a_rd_data | input | DATA_W | A read data, one cycle after the request |
| b_rd_en | output | 1 | Transposed operand read request |
| b_rd_addr | output | ADDR_W | Transposed operand read address |
| b_rd_data | input | DATA_W | Transposed operand data, one cycle after the request |
| bias_rd_en | output | 1 | Bias read request |
| bias_rd_addr | output | DIM_W | Bias read address (row index) |
| bias_rd_data | input | DATA_W | Bias data, one cycle after the request |
| c_wr_en | output | 1 | Result write strobe |
| c_wr_addr | output | ADDR_W | Result write address |
| c_wr_data | output | DATA_W | Result value |

## Verification
The bias addition and the saturating narrowing can act on the same output element. A correct design adds the bias before it clamps. If it clamped first and then added the bias, the value would wrap instead. A directed call sets up a product sum that lands just below the positive limit and a bias that pushes it past the limit. The written value must equal 32767, and the bench reference computes it by adding before narrowing. Zero padding on the K edge and on the row edge also fall on the same corner tile. Odd-sized random calls with small tiles produce such tiles, and they are judged by exact comparison with the reference and by a per-address write count.

// File: rtl/xmm_pkg.sv
package xmm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_LDRAIN,
      ST_MAC,
      ST_BIAS,
      ST_BDRAIN,
      ST_STORE,
      ST_DONE
   } xmm_state_e;

   typedef enum logic [1:0] {
      SEL_A,
      SEL_B,
      SEL_BIAS
   } xmm_sel_e;

endpackage

// File: rtl/xmm_mac_array.sv
module xmm_mac_array #(
   parameter int DW   = 16,
   parameter int AW   = 32,
   parameter int TILE = 4,
   localparam int IW  = $clog2(TILE)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 en,
   input  logic [IW-1:0]        k_idx,
   input  logic signed [DW-1:0] a_tile [TILE][TILE],
   input  logic signed [DW-1:0] b_tile [TILE][TILE],
   output logic signed [AW-1:0] acc    [TILE][TILE]
);

   for (genvar i = 0; i < TILE; i++) begin : g_row
      for (genvar j = 0; j < TILE; j++) begin : g_col
         logic signed [2*DW-1:0] prod;
         logic signed [AW-1:0]   prod_ext;
         assign prod     = a_tile[i][k_idx] * b_tile[j][k_idx];
         assign prod_ext = AW'(prod);
         always_ff @(posedge clk) begin
            if (!rst_n || clr) acc[i][j] <= '0;
            else if (en)       acc[i][j] <= acc[i][j] + prod_ext;
         end
      end
   end

endmodule

// File: rtl/xmm_out_stage.sv
module xmm_out_stage #(
   parameter int DW   = 16,
   parameter int AW   = 32,
   parameter int FRAC = 8
) (
   input  logic signed [AW-1:0] acc_in,
   input  logic signed [DW-1:0] bias_in,
   output logic        [DW-1:0] y
);

   localparam logic signed [AW-1:0] MAXV = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
   localparam logic signed [AW-1:0] MINV = ~MAXV;

   logic signed [AW-1:0] bias_ext;
   logic signed [AW-1:0] sum;
   logic signed [AW-1:0] scaled;

   always_comb begin
      bias_ext = AW'(bias_in);
      sum      = acc_in + (bias_ext <<< FRAC);
      scaled   = sum >>> FRAC;
      if (scaled > MAXV)      y = MAXV[DW-1:0];
      else if (scaled < MINV) y = MINV[DW-1:0];
      else                    y = scaled[DW-1:0];
   end

endmodule

// File: rtl/xpose_matmul.sv
module xpose_matmul #(
   parameter int DATA_W     = 16,
   parameter int ACC_W      = 32,
   parameter int FRAC_SHIFT = 8,
   parameter int TILE       = 4,
   parameter int DIM_W      = 8,
   parameter int ADDR_W     = 16,
   parameter bit USE_BIAS   = 1'b1,
   localparam int IW        = $clog2(TILE),
   localparam int TSZ_W     = IW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DIM_W-1:0]  dim_m,
   input  logic [DIM_W-1:0]  dim_n,
   input  logic [DIM_W-1:0]  dim_k,
   input  logic [TSZ_W-1:0]  tile_m,
   input  logic [TSZ_W-1:0]  tile_n,
   input  logic [TSZ_W-1:0]  tile_k,
   output logic              busy,
   output logic              done,
   output logic              a_rd_en,
   output logic [ADDR_W-1:0] a_rd_addr,
   input  logic [DATA_W-1:0] a_rd_data,
   output logic              b_rd_en,
   output logic [ADDR_W-1:0] b_rd_addr,
   input  logic [DATA_W-1:0] b_rd_data,
   output logic              bias_rd_en,
   output logic [DIM_W-1:0]  bias_rd_addr,
   input  logic [DATA_W-1:0] bias_rd_data,
   output logic              c_wr_en,
   output logic [ADDR_W-1:0] c_wr_addr,
   output logic [DATA_W-1:0] c_wr_data
);
   import xmm_pkg::*;

   localparam logic [TSZ_W-1:0] TILE_SZ = TSZ_W'(TILE);
   localparam int               PW      = DIM_W + 1;

   if (TILE < 2 || (1 << IW) != TILE) begin : g_bad_tile
      $error("TILE must be a power of two, at least 2");
   end
   if (ACC_W < 2 * DATA_W) begin : g_bad_acc
      $error("ACC_W must hold a full product");
   end
   if (FRAC_SHIFT >= ACC_W - DATA_W) begin : g_bad_frac
      $error("FRAC_SHIFT too large for ACC_W");
   end
   if (ADDR_W < 2 * DIM_W) begin : g_bad_addr
      $error("ADDR_W cannot address a full matrix");
   end

   function automatic logic [TSZ_W-1:0] fit_tile(input logic [TSZ_W-1:0] req);
      if (req == '0)     return TSZ_W'(1);
      if (req > TILE_SZ) return TILE_SZ;
      return req;
   endfunction

   xmm_state_e       state;
   xmm_sel_e         sel;
   logic [DIM_W-1:0] lm, ln, lk;
   logic [TSZ_W-1:0] tm, tn, tk;
   logic [PW-1:0]    m0, n0, k0;
   logic [IW-1:0]    r_cnt, c_cnt;

   // address and bound generation
   logic [PW-1:0]     row_base, col_base, g_row, g_col;
   logic [DIM_W-1:0]  row_lim, col_lim;
   logic              row_ok, col_ok;
   logic [ADDR_W-1:0] lin_addr;
   logic              on_b;

   always_comb begin
      on_b     = (state == ST_LOAD) && (sel == SEL_B);
      row_base = on_b ? n0 : m0;
      col_base = (state == ST_STORE) ? n0 : k0;
      row_lim  = on_b ? ln : lm;
      col_lim  = (state == ST_STORE) ? ln : lk;
      g_row    = row_base + PW'(r_cnt);
      g_col    = col_base + PW'(c_cnt);
      row_ok   = g_row < {1'b0, row_lim};
      col_ok   = g_col < {1'b0, col_lim};
      lin_addr = ADDR_W'(g_row) * ADDR_W'(col_lim) + ADDR_W'(g_col);
   end

   // loop ends
   logic          r_last_ld, r_last_m, c_last_k, c_last_n;
   logic [PW-1:0] k_next, n_next, m_next;

   always_comb begin
      r_last_ld = {1'b0, r_cnt} == ((sel == SEL_B) ? tn : tm) - 1'b1;
      r_last_m  = {1'b0, r_cnt} == tm - 1'b1;
      c_last_k  = {1'b0, c_cnt} == tk - 1'b1;
      c_last_n  = {1'b0, c_cnt} == tn - 1'b1;
      k_next    = k0 + PW'(tk);
      n_next    = n0 + PW'(tn);
      m_next    = m0 + PW'(tm);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         sel   <= SEL_A;
         lm    <= '0;
         ln    <= '0;
         lk    <= '0;
         tm    <= TSZ_W'(1);
         tn    <= TSZ_W'(1);
         tk    <= TSZ_W'(1);
         m0    <= '0;
         n0    <= '0;
         k0    <= '0;
         r_cnt <= '0;
         c_cnt <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               lm    <= dim_m;
               ln    <= dim_n;
               lk    <= dim_k;
               tm    <= fit_tile(tile_m);
               tn    <= fit_tile(tile_n);
               tk    <= fit_tile(tile_k);
               m0    <= '0;
               n0    <= '0;
               k0    <= '0;
               r_cnt <= '0;
               c_cnt <= '0;
               sel   <= SEL_A;
               state <= (dim_m == '0 || dim_n == '0 || dim_k == '0) ? ST_DONE : ST_LOAD;
            end
            ST_LOAD: if (c_last_k) begin
               c_cnt <= '0;
               if (r_last_ld) begin
                  r_cnt <= '0;
                  if (sel == SEL_A) sel <= SEL_B;
                  else begin
                     sel   <= SEL_A;
                     state <= ST_LDRAIN;
                  end
               end else r_cnt <= r_cnt + 1'b1;
            end else c_cnt <= c_cnt + 1'b1;
            ST_LDRAIN: begin
               c_cnt <= '0;
               state <= ST_MAC;
            end
            ST_MAC: if (c_last_k) begin
               c_cnt <= '0;
               r_cnt <= '0;
               if (k_next < {1'b0, lk}) begin
                  k0    <= k_next;
                  state <= ST_LOAD;
               end else begin
                  k0    <= '0;
                  state <= USE_BIAS ? ST_BIAS : ST_STORE;
               end
            end else c_cnt <= c_cnt + 1'b1;
            ST_BIAS: if (r_last_m) begin
               r_cnt <= '0;
               state <= ST_BDRAIN;
            end else r_cnt <= r_cnt + 1'b1;
            ST_BDRAIN: state <= ST_STORE;
            ST_STORE: if (c_last_n) begin
               c_cnt <= '0;
               if (r_last_m) begin
                  r_cnt <= '0;
                  if (n_next < {1'b0, ln}) begin
                     n0    <= n_next;
                     state <= ST_LOAD;
                  end else begin
                     n0 <= '0;
                     if (m_next < {1'b0, lm}) begin
                        m0    <= m_next;
                        state <= ST_LOAD;
                     end else state <= ST_DONE;
                  end
               end else r_cnt <= r_cnt + 1'b1;
            end else c_cnt <= c_cnt + 1'b1;
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   // one-cycle read pipeline into tile buffers
   logic          p_v, p_inb;
   xmm_sel_e      p_sel;
   logic [IW-1:0] p_r, p_c;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         p_v   <= 1'b0;
         p_inb <= 1'b0;
         p_sel <= SEL_A;
         p_r   <= '0;
         p_c   <= '0;
      end else begin
         p_v   <= (state == ST_LOAD) || (state == ST_BIAS);
         p_inb <= row_ok && ((state == ST_BIAS) || col_ok);
         p_sel <= (state == ST_BIAS) ? SEL_BIAS : sel;
         p_r   <= r_cnt;
         p_c   <= c_cnt;
      end
   end

   logic signed [DATA_W-1:0] a_buf [TILE][TILE];
   logic signed [DATA_W-1:0] b_buf [TILE][TILE];
   logic signed [DATA_W-1:0] bias_sel;

   always_ff @(posedge clk) begin
      if (p_v && p_sel == SEL_A) a_buf[p_r][p_c] <= p_inb ? $signed(a_rd_data) : '0;
      if (p_v && p_sel == SEL_B) b_buf[p_r][p_c] <= p_inb ? $signed(b_rd_data) : '0;
   end

   if (USE_BIAS) begin : g_bias
      logic signed [DATA_W-1:0] bias_q [TILE];
      always_ff @(posedge clk) begin
         if (p_v && p_sel == SEL_BIAS) bias_q[p_r] <= p_inb ? $signed(bias_rd_data) : '0;
      end
      assign bias_sel = bias_q[r_cnt];
   end else begin : g_nobias
      logic unused_bias;
      assign unused_bias = ^bias_rd_data;
      assign bias_sel    = '0;
   end

   logic signed [ACC_W-1:0] acc [TILE][TILE];
   logic                    mac_clr;

   assign mac_clr = ((state == ST_IDLE) && start) ||
                    ((state == ST_STORE) && c_last_n && r_last_m);

   xmm_mac_array #(.DW(DATA_W), .AW(ACC_W), .TILE(TILE)) u_mac (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (mac_clr),
      .en     (state == ST_MAC),
      .k_idx  (c_cnt),
      .a_tile (a_buf),
      .b_tile (b_buf),
      .acc    (acc)
   );

   xmm_out_stage #(.DW(DATA_W), .AW(ACC_W), .FRAC(FRAC_SHIFT)) u_out (
      .acc_in  (acc[r_cnt][c_cnt]),
      .bias_in (bias_sel),
      .y       (c_wr_data)
   );

   assign busy         = (state != ST_IDLE) && (state != ST_DONE);
   assign done         = (state == ST_DONE);
   assign a_rd_en      = (state == ST_LOAD) && (sel == SEL_A) && row_ok && col_ok;
   assign b_rd_en      = on_b && row_ok && col_ok;
   assign a_rd_addr    = lin_addr;
   assign b_rd_addr    = lin_addr;
   assign bias_rd_en   = (state == ST_BIAS) && row_ok;
   assign bias_rd_addr = DIM_W'(g_row);
   assign c_wr_en      = (state == ST_STORE) && row_ok && col_ok;
   assign c_wr_addr    = lin_addr;

endmodule

// File: rtl/xpose_matmul_chk.sv
module xpose_matmul_chk #(
   parameter int DIM_W  = 8,
   parameter int ADDR_W = 16,
   parameter int IW     = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              a_rd_en,
   input logic [ADDR_W-1:0] a_rd_addr,
   input logic              b_rd_en,
   input logic [ADDR_W-1:0] b_rd_addr,
   input logic              bias_rd_en,
   input logic              c_wr_en,
   input logic [ADDR_W-1:0] c_wr_addr,
   input logic [DIM_W-1:0]  lm,
   input logic [DIM_W-1:0]  ln,
   input logic [DIM_W-1:0]  lk,
   input logic [IW-1:0]     r_cnt
);

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   // R9
   start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !done) |=> (busy || done));

   // R10
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable({lm, ln, lk}));

   // R5
   b_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (b_rd_en && $past(b_rd_en) && r_cnt == $past(r_cnt))
      |-> b_rd_addr == $past(b_rd_addr) + ADDR_W'(1));

   // R5
   a_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_rd_en && $past(a_rd_en) && r_cnt == $past(r_cnt))
      |-> a_rd_addr == $past(a_rd_addr) + ADDR_W'(1));

   // R6
   a_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      a_rd_en |-> a_rd_addr < ADDR_W'(lm) * ADDR_W'(lk));

   // R6
   b_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      b_rd_en |-> b_rd_addr < ADDR_W'(ln) * ADDR_W'(lk));

   // R7
   c_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c_wr_en |-> c_wr_addr < ADDR_W'(lm) * ADDR_W'(ln));

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !(a_rd_en || b_rd_en || bias_rd_en || c_wr_en));

endmodule

bind xpose_matmul xpose_matmul_chk #(.DIM_W(DIM_W), .ADDR_W(ADDR_W), .IW(IW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .busy       (busy),
   .done       (done),
   .a_rd_en    (a_rd_en),
   .a_rd_addr  (a_rd_addr),
   .b_rd_en    (b_rd_en),
   .b_rd_addr  (b_rd_addr),
   .bias_rd_en (bias_rd_en),
   .c_wr_en    (c_wr_en),
   .c_wr_addr  (c_wr_addr),
   .lm         (lm),
   .ln         (ln),
   .lk         (lk),
   .r_cnt      (r_cnt)
);

// File: tb/test_xpose_matmul.sv
`timescale 1ns/1ps
module test_xpose_matmul;

   localparam int DW    = 16;
   localparam int DIM_W = 8;
   localparam int AW    = 16;
   localparam int FRAC  = 8;
   localparam int TSZ_W = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [DIM_W-1:0]  dim_m = '0, dim_n = '0, dim_k = '0;
   logic [TSZ_W-1:0]  tile_m = '0, tile_n = '0, tile_k = '0;
   logic              busy, done;
   logic              a_rd_en, b_rd_en, bias_rd_en, c_wr_en;
   logic [AW-1:0]     a_rd_addr, b_rd_addr, c_wr_addr;
   logic [DIM_W-1:0]  bias_rd_addr;
   logic [DW-1:0]     a_rd_data = '0, b_rd_data = '0, bias_rd_data = '0, c_wr_data;

   always #2.5 clk = ~clk;

   xpose_matmul #(.DATA_W(DW), .ACC_W(32), .FRAC_SHIFT(FRAC), .TILE(4),
                  .DIM_W(DIM_W), .ADDR_W(AW), .USE_BIAS(1'b1)) i_xpose_matmul (
      .clk(clk), .rst_n(rst_n), .start(start),
      .dim_m(dim_m), .dim_n(dim_n), .dim_k(dim_k),
      .tile_m(tile_m), .tile_n(tile_n), .tile_k(tile_k),
      .busy(busy), .done(done),
      .a_rd_en(a_rd_en), .a_rd_addr(a_rd_addr), .a_rd_data(a_rd_data),
      .b_rd_en(b_rd_en), .b_rd_addr(b_rd_addr), .b_rd_data(b_rd_data),
      .bias_rd_en(bias_rd_en), .bias_rd_addr(bias_rd_addr), .bias_rd_data(bias_rd_data),
      .c_wr_en(c_wr_en), .c_wr_addr(c_wr_addr), .c_wr_data(c_wr_data)
   );

   logic [DW-1:0] a_mem [0:255];
   logic [DW-1:0] b_mem [0:255];
   logic [DW-1:0] bias_mem [0:15];
   logic [DW-1:0] c_mem [0:255];
   int            wcnt [0:255];
   int            cur_m, cur_n, cur_k;
   int            rd_cnt, oob_cnt, wr_cnt, wr_oob;
   int            n_chk = 0, n_fail = 0;

   always @(posedge clk) begin
      if (a_rd_en) begin
         a_rd_data <= a_mem[a_rd_addr[7:0]];
         rd_cnt = rd_cnt + 1;
         if (int'(a_rd_addr) >= cur_m * cur_k) oob_cnt = oob_cnt + 1;
      end
      if (b_rd_en) begin
         b_rd_data <= b_mem[b_rd_addr[7:0]];
         rd_cnt = rd_cnt + 1;
         if (int'(b_rd_addr) >= cur_n * cur_k) oob_cnt = oob_cnt + 1;
      end
      if (bias_rd_en) begin
         bias_rd_data <= bias_mem[bias_rd_addr[3:0]];
         rd_cnt = rd_cnt + 1;
         if (int'(bias_rd_addr) >= cur_m) oob_cnt = oob_cnt + 1;
      end
      if (c_wr_en) begin
         wr_cnt = wr_cnt + 1;
         if (int'(c_wr_addr) >= cur_m * cur_n) wr_oob = wr_oob + 1;
         else begin
            c_mem[c_wr_addr[7:0]] <= c_wr_data;
            wcnt[c_wr_addr[7:0]] = wcnt[c_wr_addr[7:0]] + 1;
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int ref_elem(input int m, input int n);
      int acc = 0;
      for (int kk = 0; kk < cur_k; kk++)
         acc += int'($signed(a_mem[m*cur_k+kk])) * int'($signed(b_mem[n*cur_k+kk]));
      acc += int'($signed(bias_mem[m])) * (1 << FRAC);
      acc = acc >>> FRAC;
      if (acc > 32767) acc = 32767;
      if (acc < -32768) acc = -32768;
      return acc;
   endfunction

   function automatic logic [DW-1:0] rnd_val(input int mode);
      if (mode == 0) return DW'($urandom_range(127)) - DW'(64);
      return DW'($urandom);
   endfunction

   // mode 0: small values, 1: full range, 2: memory preloaded by caller
   task automatic run_case(input int m, input int n, input int k,
                           input int tm, input int tn, input int tk,
                           input int mode, input bit inject, input string req);
      int cyc = 0;
      int bad = 0, first_act = 0, first_exp = 0, bad_w = 0;
      cur_m = m; cur_n = n; cur_k = k;
      if (mode != 2) begin
         for (int i = 0; i < m*k; i++) a_mem[i] = rnd_val(mode);
         for (int i = 0; i < n*k; i++) b_mem[i] = rnd_val(mode);
         for (int i = 0; i < 16; i++)  bias_mem[i] = rnd_val(0);
      end
      for (int i = 0; i < 256; i++) begin c_mem[i] = '0; wcnt[i] = 0; end
      rd_cnt = 0; oob_cnt = 0; wr_cnt = 0; wr_oob = 0;
      @(negedge clk);
      dim_m = DIM_W'(m); dim_n = DIM_W'(n); dim_k = DIM_W'(k);
      tile_m = TSZ_W'(tm); tile_n = TSZ_W'(tn); tile_k = TSZ_W'(tk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy === 1'b1, "R9", int'(busy), 1, {req, " busy after start"});
      while (done !== 1'b1 && cyc < 20000) begin
         @(negedge clk);
         cyc++;
         if (inject && cyc == 5) begin
            dim_m = 8'd1; dim_n = 8'd1; dim_k = 8'd1; tile_m = 3'd1;
            start = 1'b1;
         end
         if (inject && cyc == 6) start = 1'b0;
      end
      check(done === 1'b1, "R9", cyc, 0, {req, " done reached"});
      @(negedge clk);
      check(done === 1'b0 && busy === 1'b0, "R9", int'({done, busy}), 0, {req, " done one cycle"});
      for (int i = 0; i < m; i++)
         for (int j = 0; j < n; j++) begin
            int e = ref_elem(i, j);
            int a = int'($signed(c_mem[i*n+j]));
            if (a != e || wcnt[i*n+j] != 1) begin
               if (bad == 0) begin first_act = a; first_exp = e; end
               bad++;
            end
            if (wcnt[i*n+j] != 1) bad_w++;
         end
      check(bad == 0, req, first_act, first_exp, "result element");
      check(bad_w == 0 && wr_oob == 0 && wr_cnt == m*n, "R7", wr_cnt, m*n, {req, " write count"});
      check(oob_cnt == 0, "R6", oob_cnt, 0, {req, " out-of-bounds reads"});
   endtask

   initial begin
      #(200000 * 5);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd4271));
      repeat (3) @(negedge clk);
      // R1 reset state
      check(!busy && !done && !a_rd_en && !b_rd_en && !bias_rd_en && !c_wr_en, "R1",
            int'({busy, done, a_rd_en, b_rd_en, bias_rd_en, c_wr_en}), 0, "reset outputs");
      rst_n = 1'b1;
      @(negedge clk);

      run_case(4, 4, 4, 4, 4, 4, 0, 1'b0, "R2");
      run_case(5, 6, 7, 4, 4, 4, 0, 1'b0, "R6");
      run_case(3, 3, 9, 2, 3, 2, 0, 1'b0, "R4");
      run_case(5, 5, 5, 0, 7, 0, 0, 1'b0, "R8");
      run_case(7, 3, 6, 4, 4, 3, 1, 1'b0, "R5");

      // R3 directed saturation, both signs
      for (int i = 0; i < 4; i++) a_mem[i] = DW'(3000);
      b_mem[0] = DW'(3000); b_mem[1] = DW'(3000);
      b_mem[2] = DW'(-3000); b_mem[3] = DW'(-3000);
      bias_mem[0] = '0; bias_mem[1] = '0;
      run_case(2, 2, 2, 2, 2, 2, 2, 1'b0, "R3");
      check(c_mem[1] == 16'h8000, "R3", int'($signed(c_mem[1])), -32768, "negative clamp");

      // R3 + R4 bias pushes past the positive limit
      a_mem[0] = DW'(32700); b_mem[0] = DW'(256); bias_mem[0] = DW'(100);
      run_case(1, 1, 1, 1, 1, 1, 2, 1'b0, "R3");
      check(c_mem[0] == 16'h7FFF, "R4", int'($signed(c_mem[0])), 32767, "bias then clamp");

      // R10 start during busy
      run_case(6, 5, 8, 3, 2, 4, 0, 1'b1, "R10");

      for (int t = 0; t < 6; t++)
         run_case(1 + $urandom_range(11), 1 + $urandom_range(11), 1 + $urandom_range(11),
                  1 + $urandom_range(3), 1 + $urandom_range(3), 1 + $urandom_range(3),
                  $urandom_range(1), 1'b0, "R2");

      // R11 zero dimension
      begin
         int cyc = 0;
         bit seen = 1'b0;
         cur_m = 0; cur_n = 4; cur_k = 4;
         rd_cnt = 0; wr_cnt = 0;
         @(negedge clk);
         dim_m = '0; dim_n = 8'd4; dim_k = 8'd4; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         while (cyc < 8) begin
            if (done === 1'b1) seen = 1'b1;
            @(negedge clk);
            cyc++;
         end
         check(seen && rd_cnt == 0 && wr_cnt == 0, "R11", rd_cnt + wr_cnt, 0, "zero dimension call");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule